// File: doc/BRIEF.md
# SRAM Test Packet Scan Register

This block holds a 112-bit test packet and uses it to drive a bank of dual-port SRAM macros. The packet is shifted in one bit per clock, most significant bit first, on a serial input while scan enable is high. At the same time the previous contents leave on the serial output. The packet fields are decoded onto shared address, data, write-enable and byte-mask buses. A 4-bit select field then lowers the chip selects of exactly one macro, for each port whose packet chip select is active.

After an SRAM operation, a load-result strobe copies the read data of the selected macro back into the packet's data fields. The tester then shifts the packet out and compares it. A read result replaces the data field in place, and only for a port that performed a read. A global disable input holds every chip select inactive. The tester keeps it high while the packet is shifting, so partial packets never reach the memories. One macro position may hold a 64-bit macro. Only its upper and lower 16-bit halves are mapped, and its middle 32 bits are driven to zero.

Top module: `sramtest_scan_top`

## Requirements
- R1: A high `rst` on a clock edge clears all 112 packet bits to zero.
- R2: While `scan_en` is high and `load_res` is low, each clock shifts the packet left by one, with `scan_in` entering bit 0. `scan_out` always shows bit 111. While both are low, the packet holds.
- R3: Packet layout from bit 111 down: select (4), addr0 (16), data0 (32), csb0 (1), web0 (1), wmask0 (4), addr1 (16), data1 (32), csb1 (1), web1 (1), wmask1 (4).
- R4: With `csb_all` low, `mem_csb0[i]` is low only when i equals the select field and the csb0 field is 0. `mem_csb1` follows the same rule with the csb1 field. All chip selects are active low.
- R5: While `csb_all` is high, every bit of `mem_csb0` and `mem_csb1` is high, and no macro is written, whatever the packet holds.
- R6: A clock with `load_res` high replaces data0 with the selected macro's port-0 read data when csb0=0 and web0=1 (read). data1 is handled the same way for port 1. A port that is writing or idle keeps its data field. The other fields are unchanged.
- R7: For the 64-bit macro at index `WIDE_IDX`, the write data is {data[31:16], 32'b0, data[15:0]}. Its read data loads back as {dout[63:48], dout[15:0]}.
- R8: When `load_res` and `scan_en` are both high, the load takes effect and no shift happens.
- R9: `mem_addrN`, `mem_dinN`, `mem_webN` and `mem_wmaskN` equal the matching packet fields of port N. wmask bit b enables byte b, active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and SRAM clock |
| rst | input | 1 | Synchronous scan reset, active high |
| scan_en | input | 1 | Shift enable |
| scan_in | input | 1 | Serial packet input |
| load_res | input | 1 | Capture read data into the packet |
| csb_all | input | 1 | Global chip-select disable, active high |
| scan_out | output | 1 | Serial packet output (bit 111) |
| mem_csb0 | output | NMEM | Per-macro port-0 chip select, active low |
| mem_addr0 | output | 16 | Port-0 address |
| mem_din0 | output | 32 | Port-0 write data |
| mem_din0_w | output | 64 | Port-0 write data for the 64-bit macro |
| mem_web0 | output | 1 | Port-0 write enable, active low |
| mem_wmask0 | output | 4 | Port-0 byte mask |
| mem_csb1 | output | NMEM | Per-macro port-1 chip select, active low |
| mem_addr1 | output | 16 | Port-1 address |
| mem_din1 | output | 32 | Port-1 write data |
| mem_din1_w | output | 64 | Port-1 write data for the 64-bit macro |
| mem_web1 | output | 1 | Port-1 write enable, active low |
| mem_wmask1 | output | 4 | Port-1 byte mask |
| mem_dout0 | input | NMEM*32 | Port-0 read data, macro i at bits [32i+31:32i] |
| mem_dout1 | input | NMEM*32 | Port-1 read data, same packing |
| mem_dout0_w | input | 64 | Port-0 read data of the 64-bit macro |
| mem_dout1_w | input | 64 | Port-1 read data of the 64-bit macro |

## Verification
The assertions check several rules on every cycle: the clear after reset, the one-position shift, the hold when idle, load priority over shifting, the rule that at most one macro is selected per port, the effect of the global disable, and that a writing port keeps its data field through a load. Other behaviour shows only through the bench's scenarios against behavioural memories: byte-masked writes landing in the right macro, read data returning into the right field, the folding of the 64-bit macro's halves, and the fact that a write attempted under the global disable leaves the memory contents untouched.

// File: rtl/sramtest_pkg.sv
package sramtest_pkg;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int MASK_W = 4;
  localparam int WIDE_W = 2 * DATA_W;
  localparam int PKT_W  = SEL_W + 2 * (ADDR_W + DATA_W + 2 + MASK_W);

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] a0;
    logic [DATA_W-1:0] d0;
    logic              cs0_n;
    logic              we0_n;
    logic [MASK_W-1:0] m0;
    logic [ADDR_W-1:0] a1;
    logic [DATA_W-1:0] d1;
    logic              cs1_n;
    logic              we1_n;
    logic [MASK_W-1:0] m1;
  } pkt_t;
endpackage

// File: rtl/pkt_shift_reg.sv
module pkt_shift_reg #(
  parameter int W = 112
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         shift_in,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] pkt_q,
  output logic         shift_out
);
  always_ff @(posedge clk) begin
    if (rst)           pkt_q <= '0;
    else if (load_en)  pkt_q <= load_val;
    else if (shift_en) pkt_q <= {pkt_q[W-2:0], shift_in};
  end

  assign shift_out = pkt_q[W-1];

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (pkt_q == '0)); // R1
  AST_SHIFT_ONE: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !load_en) |=> (pkt_q == {$past(pkt_q[W-2:0]), $past(shift_in)})); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !load_en) |=> $stable(pkt_q)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (pkt_q == $past(load_val))); // R8
endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int NMEM  = 16,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             port_cs_n,
  input  logic             all_off,
  output logic [NMEM-1:0]  cs_n
);
  for (genvar i = 0; i < NMEM; i++) begin : g_cs
    assign cs_n[i] = all_off | port_cs_n | (sel != SEL_W'(i));
  end
endmodule

// File: rtl/data_fold.sv
module data_fold #(
  parameter int NW = 32
) (
  input  logic [NW-1:0]   nar_in,
  output logic [2*NW-1:0] wide_out,
  input  logic [2*NW-1:0] wide_in,
  output logic [NW-1:0]   nar_out
);
  localparam int HW = NW / 2;

  assign wide_out = {nar_in[NW-1:HW], {NW{1'b0}}, nar_in[HW-1:0]};
  assign nar_out  = {wide_in[2*NW-1:2*NW-HW], wide_in[HW-1:0]};
endmodule

// File: rtl/sramtest_scan_top.sv
module sramtest_scan_top
  import sramtest_pkg::*;
#(
  parameter int NMEM     = 16,
  parameter int WIDE_IDX = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_en,
  input  logic                 scan_in,
  input  logic                 load_res,
  input  logic                 csb_all,
  output logic                 scan_out,
  output logic [NMEM-1:0]      mem_csb0,
  output logic [ADDR_W-1:0]    mem_addr0,
  output logic [DATA_W-1:0]    mem_din0,
  output logic [WIDE_W-1:0]    mem_din0_w,
  output logic                 mem_web0,
  output logic [MASK_W-1:0]    mem_wmask0,
  output logic [NMEM-1:0]      mem_csb1,
  output logic [ADDR_W-1:0]    mem_addr1,
  output logic [DATA_W-1:0]    mem_din1,
  output logic [WIDE_W-1:0]    mem_din1_w,
  output logic                 mem_web1,
  output logic [MASK_W-1:0]    mem_wmask1,
  input  logic [NMEM*DATA_W-1:0] mem_dout0,
  input  logic [NMEM*DATA_W-1:0] mem_dout1,
  input  logic [WIDE_W-1:0]    mem_dout0_w,
  input  logic [WIDE_W-1:0]    mem_dout1_w
);
  logic [PKT_W-1:0]  pkt_bits;
  logic [PKT_W-1:0]  nxt_bits;
  pkt_t              pkt;
  pkt_t              merged;
  logic [DATA_W-1:0] rd0, rd1, fold0, fold1;

  assign pkt = pkt_t'(pkt_bits);

  pkt_shift_reg #(.W(PKT_W)) i_sreg (
    .clk(clk), .rst(rst), .shift_en(scan_en), .shift_in(scan_in),
    .load_en(load_res), .load_val(nxt_bits),
    .pkt_q(pkt_bits), .shift_out(scan_out)
  );

  sel_decode #(.NMEM(NMEM), .SEL_W(SEL_W)) i_dec0 (
    .sel(pkt.sel), .port_cs_n(pkt.cs0_n), .all_off(csb_all), .cs_n(mem_csb0)
  );
  sel_decode #(.NMEM(NMEM), .SEL_W(SEL_W)) i_dec1 (
    .sel(pkt.sel), .port_cs_n(pkt.cs1_n), .all_off(csb_all), .cs_n(mem_csb1)
  );

  data_fold #(.NW(DATA_W)) i_fold0 (
    .nar_in(pkt.d0), .wide_out(mem_din0_w), .wide_in(mem_dout0_w), .nar_out(fold0)
  );
  data_fold #(.NW(DATA_W)) i_fold1 (
    .nar_in(pkt.d1), .wide_out(mem_din1_w), .wide_in(mem_dout1_w), .nar_out(fold1)
  );

  assign mem_addr0  = pkt.a0;
  assign mem_din0   = pkt.d0;
  assign mem_web0   = pkt.we0_n;
  assign mem_wmask0 = pkt.m0;
  assign mem_addr1  = pkt.a1;
  assign mem_din1   = pkt.d1;
  assign mem_web1   = pkt.we1_n;
  assign mem_wmask1 = pkt.m1;

  // Read-data selection: the wide slot takes its folded bus
  always_comb begin
    rd0 = '0;
    rd1 = '0;
    for (int i = 0; i < NMEM; i++) begin
      if (pkt.sel == SEL_W'(i)) begin
        if (i == WIDE_IDX) begin
          rd0 = fold0;
          rd1 = fold1;
        end else begin
          rd0 = mem_dout0[i*DATA_W +: DATA_W];
          rd1 = mem_dout1[i*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_comb begin
    merged = pkt;
    if (!pkt.cs0_n && pkt.we0_n) merged.d0 = rd0;
    if (!pkt.cs1_n && pkt.we1_n) merged.d1 = rd1;
  end
  assign nxt_bits = PKT_W'(merged);

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_csb0) && $onehot0(~mem_csb1)); // R4
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    csb_all |-> ((&mem_csb0) && (&mem_csb1))); // R5
  AST_WRITER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (load_res && !pkt.we0_n) |=> (pkt.d0 == $past(pkt.d0))); // R6
  AST_WIDE_MID: assert property (@(posedge clk) disable iff (rst)
    (mem_din0_w[47:16] == 32'h0) && (mem_din1_w[47:16] == 32'h0)); // R7
endmodule

// File: tb/test_sramtest_scan_top.sv
`timescale 1ns/1ps
module test_sramtest_scan_top;
  localparam int NM = 16;
  localparam int WI = 15;

  logic clk = 0;
  logic rst = 1, scan_en = 0, scan_in = 0, load_res = 0, csb_all = 1;
  logic scan_out;
  logic [NM-1:0] csb0, csb1;
  logic [15:0] a0, a1;
  logic [31:0] d0, d1;
  logic [63:0] d0w, d1w;
  logic web0, web1;
  logic [3:0] m0, m1;
  logic [NM*32-1:0] q0, q1;
  logic [63:0] q0w, q1w;

  always #10 clk = ~clk;

  sramtest_scan_top #(.NMEM(NM), .WIDE_IDX(WI)) i_sramtest_scan_top (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
    .load_res(load_res), .csb_all(csb_all), .scan_out(scan_out),
    .mem_csb0(csb0), .mem_addr0(a0), .mem_din0(d0), .mem_din0_w(d0w),
    .mem_web0(web0), .mem_wmask0(m0),
    .mem_csb1(csb1), .mem_addr1(a1), .mem_din1(d1), .mem_din1_w(d1w),
    .mem_web1(web1), .mem_wmask1(m1),
    .mem_dout0(q0), .mem_dout1(q1), .mem_dout0_w(q0w), .mem_dout1_w(q1w)
  );

  // Behavioural memories: 16 words each, synchronous read
  logic [31:0] nmem [NM][16];
  logic [63:0] wmem [16];
  logic [31:0] r0 [NM];
  logic [31:0] r1 [NM];

  function automatic logic [31:0] bmask(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = m[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] wmask64(input logic [63:0] o, input logic [63:0] n,
                                          input logic [3:0] m);
    logic [63:0] r;
    r = {o[63:48], n[47:16], o[15:0]};
    if (m[0]) r[7:0]   = n[7:0];
    if (m[1]) r[15:8]  = n[15:8];
    if (m[2]) r[55:48] = n[55:48];
    if (m[3]) r[63:56] = n[63:56];
    return r;
  endfunction

  initial begin
    for (int i = 0; i < NM; i++) begin
      r0[i] = '0; r1[i] = '0;
      for (int j = 0; j < 16; j++) nmem[i][j] = '0;
    end
    for (int j = 0; j < 16; j++) wmem[j] = '0;
    q0w = '0; q1w = '0;
  end

  always @(posedge clk) begin
    for (int i = 0; i < NM; i++) begin
      if (i == WI) begin
        if (!csb0[i]) begin
          if (!web0) wmem[a0[3:0]] <= wmask64(wmem[a0[3:0]], d0w, m0);
          else q0w <= wmem[a0[3:0]];
        end
        if (!csb1[i]) begin
          if (!web1) wmem[a1[3:0]] <= wmask64(wmem[a1[3:0]], d1w, m1);
          else q1w <= wmem[a1[3:0]];
        end
      end else begin
        if (!csb0[i]) begin
          if (!web0) nmem[i][a0[3:0]] <= bmask(nmem[i][a0[3:0]], d0, m0);
          else r0[i] <= nmem[i][a0[3:0]];
        end
        if (!csb1[i]) begin
          if (!web1) nmem[i][a1[3:0]] <= bmask(nmem[i][a1[3:0]], d1, m1);
          else r1[i] <= nmem[i][a1[3:0]];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      q0[i*32 +: 32] = (i == WI) ? 32'h0 : r0[i];
      q1[i*32 +: 32] = (i == WI) ? 32'h0 : r1[i];
    end
  end

  int n_tests = 0, n_fail = 0;
  logic [111:0] exp_reg = '0;
  logic [111:0] expq [$];
  logic [111:0] gotq [$];
  event got_ev;

  task automatic chk(input bit ok, input string tag, input logic [111:0] act,
                     input logic [111:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [111:0] mk(
      input logic [3:0] s, input logic [15:0] aa0, input logic [31:0] dd0,
      input logic c0, input logic w0, input logic [3:0] mm0,
      input logic [15:0] aa1, input logic [31:0] dd1,
      input logic c1, input logic w1, input logic [3:0] mm1);
    return {s, aa0, dd0, c0, w0, mm0, aa1, dd1, c1, w1, mm1};
  endfunction

  // Monitor: pops expected packets and compares with shifted-out ones
  initial begin
    forever begin
      @(got_ev);
      while (gotq.size() > 0 && expq.size() > 0) begin
        logic [111:0] g, e;
        g = gotq.pop_front();
        e = expq.pop_front();
        chk(g === e, "R2/R6 scoreboard packet", g, e);
      end
    end
  end

  // Driver: shift a packet in while capturing the old one
  task automatic shift_all(input logic [111:0] p);
    logic [111:0] got;
    expq.push_back(exp_reg);
    for (int i = 0; i < 112; i++) begin
      @(negedge clk);
      got[111-i] = scan_out;
      scan_en = 1; scan_in = p[111-i];
    end
    @(negedge clk);
    scan_en = 0; scan_in = 0;
    exp_reg = p;
    gotq.push_back(got);
    ->got_ev;
  endtask

  // One SRAM cycle with chip selects released
  task automatic fire();
    csb_all = 0;
    @(negedge clk);
    csb_all = 1;
  endtask

  task automatic load_pulse(input logic [111:0] after);
    load_res = 1;
    @(negedge clk);
    load_res = 0;
    exp_reg = after;
  endtask

  logic [111:0] p;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    // R1: cleared packet, macro 0 selected on both ports once csb_all drops
    chk(scan_out === 1'b0, "R1 scan_out after reset", {111'b0, scan_out}, 112'h0);
    csb_all = 0; #1;
    chk(csb0 === 16'hFFFE && csb1 === 16'hFFFE, "R1/R4 cleared select",
        {80'b0, csb0, csb1}, {80'b0, 32'hFFFEFFFE});
    @(negedge clk); csb_all = 1;
    exp_reg = '0;

    // P1: write macro 3 port 0
    p = mk(4'd3, 16'd5, 32'hA5A51234, 1'b0, 1'b0, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_all(p);
    #1;
    chk(csb0 === '1 && csb1 === '1, "R5 all off under csb_all",
        {80'b0, csb0, csb1}, {80'b0, 32'hFFFFFFFF});
    chk(a0 === 16'd5 && d0 === 32'hA5A51234 && web0 === 1'b0 && m0 === 4'hF,
        "R9/R3 port0 fields", {60'b0, a0, d0, web0, m0}, {60'b0, 16'd5, 32'hA5A51234, 1'b0, 4'hF});
    csb_all = 0; #1;
    chk(csb0 === 16'hFFF7 && csb1 === 16'hFFFF, "R4 macro 3 port0 only",
        {80'b0, csb0, csb1}, {80'b0, 32'hFFF7FFFF});
    @(negedge clk); csb_all = 1;

    // P2: masked write on port 1
    p = mk(4'd3, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0, 16'd6, 32'hFFFFFFFF, 1'b0, 1'b0, 4'b0101);
    shift_all(p);
    csb_all = 0; #1;
    chk(csb1 === 16'hFFF7 && csb0 === 16'hFFFF, "R4 macro 3 port1 only",
        {80'b0, csb0, csb1}, {80'b0, 32'hFFFFFFF7});
    chk(a1 === 16'd6 && m1 === 4'b0101 && web1 === 1'b0, "R9 port1 fields",
        {91'b0, a1, m1, web1}, {91'b0, 16'd6, 4'b0101, 1'b0});
    @(negedge clk); csb_all = 1;

    // P3: read both ports, load (R6)
    p = mk(4'd3, 16'd5, 32'h11111111, 1'b0, 1'b1, 4'h0, 16'd6, 32'h22222222, 1'b0, 1'b1, 4'h0);
    shift_all(p);
    fire();
    load_pulse(mk(4'd3, 16'd5, 32'hA5A51234, 1'b0, 1'b1, 4'h0, 16'd6, 32'h00FF00FF, 1'b0, 1'b1, 4'h0));

    // P4: port0 reads, port1 writes -> data1 kept (R6)
    p = mk(4'd3, 16'd5, 32'h33333333, 1'b0, 1'b1, 4'h0, 16'd9, 32'h44444444, 1'b0, 1'b0, 4'hF);
    shift_all(p);
    fire();
    load_pulse(mk(4'd3, 16'd5, 32'hA5A51234, 1'b0, 1'b1, 4'h0, 16'd9, 32'h44444444, 1'b0, 1'b0, 4'hF));

    // P5: other macro sees nothing (R4 isolation)
    p = mk(4'd7, 16'd5, 32'h55555555, 1'b0, 1'b1, 4'h0, 16'd9, 32'h66666666, 1'b0, 1'b1, 4'h0);
    shift_all(p);
    fire();
    load_pulse(mk(4'd7, 16'd5, 32'h0, 1'b0, 1'b1, 4'h0, 16'd9, 32'h0, 1'b0, 1'b1, 4'h0));

    // P6: wide macro write, fold check (R7)
    p = mk(4'd15, 16'd2, 32'hDEADBEEF, 1'b0, 1'b0, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_all(p);
    #1;
    chk(scan_out === 1'b1, "R2 msb first on serial out", {111'b0, scan_out}, 112'h1);
    chk(d0w === 64'hDEAD00000000BEEF, "R7 wide write fold", {48'b0, d0w}, {48'b0, 64'hDEAD00000000BEEF});
    fire();

    // P7: wide readback (R7)
    p = mk(4'd15, 16'd2, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_all(p);
    fire();
    load_pulse(mk(4'd15, 16'd2, 32'hDEADBEEF, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));

    // P8: write attempt held off by csb_all (R5)
    p = mk(4'd3, 16'd5, 32'h77777777, 1'b0, 1'b0, 4'hF, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_all(p);
    @(negedge clk);
    p = mk(4'd3, 16'd5, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_all(p);
    fire();
    load_pulse(mk(4'd3, 16'd5, 32'hA5A51234, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));

    // P9: load and shift together, load wins (R8)
    p = mk(4'd3, 16'd6, 32'h0, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0);
    shift_all(p);
    fire();
    scan_en = 1; scan_in = 1;
    load_pulse(mk(4'd3, 16'd6, 32'h00FF00FF, 1'b0, 1'b1, 4'h0, 16'd0, 32'h0, 1'b1, 1'b1, 4'h0));
    scan_en = 0; scan_in = 0;

    // Idle with toggling serial input: packet must hold (R2)
    for (int k = 0; k < 8; k++) begin
      scan_in = k[0];
      @(negedge clk);
    end
    scan_in = 0;
    shift_all('0);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2 scoreboard drained", 112'(expq.size()), 112'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule